// File: doc/BRIEF.md
# Multistage Parallel Interference Canceller

This block takes one symbol period of a synchronous BPSK spread-spectrum signal: sixteen received chips and the spreading codes of up to fifteen users. A bank of correlators first despreads every user against the raw chips. That pass gives a correlation, a hard bit decision and a fixed amplitude estimate for each user.

Each cancellation stage then works from the previous decisions. It rebuilds every user's chip-level contribution from its decision and amplitude and sums those contributions per chip. For each user it takes the original chips, removes the sum, and adds back that user's own term, which removes only the other users' interference. It then correlates that user again to get a new correlation and decision. All users are updated together from the same previous decisions.

A stage count sampled with the symbol selects 0 to 3 stages. A count of 3 is the normal operating point, and 0 returns the plain matched-filter result.

The symbol enters on a valid/ready handshake and the result leaves on a second one. The block holds one symbol at a time:
- `in_ready` is high only while the block is empty.
- A result waiting at the output is held until the sink takes it.
- While a result is held, no new symbol is accepted, so back-pressure on the output stalls the input.

Top module: `pic_canceller`

## Requirements
- R1: `in_ready` is high only when no symbol is in flight. On a rising edge with `in_valid` and `in_ready` both high, the chips, codes and stage count are captured. Later changes on those inputs do not affect that symbol's result.
- R2: Once `out_valid` rises, it stays high and `dec_o`/`corr_o` stay unchanged until a rising edge with `out_ready` high. The symbol is released on that edge. While `out_valid` is high, `in_ready` stays low and `in_valid` is ignored. `in_ready` returns high the cycle after release.
- R3: The matched-filter correlation of user u is the sum over chips c of r_c·w_u(c). Chip c of `rx_chips` sits at bits [8c+7:8c], two's complement. w_u(c) is +1 when bit 16u+c of `spread_codes` is 0 and −1 when it is 1.
- R4: `dec_o[u]` is 1 (bit +1) when the user's current correlation is zero or positive, and 0 (bit −1) when it is negative.
- R5: Each user's amplitude estimate is floor(|matched-filter correlation| / 16). It is set once per symbol and stays unchanged through all cancellation stages.
- R6: In each stage, user u is re-correlated against y_c = r_c − Σ_v d_v·A_v·w_v(c) + d_u·A_u·w_u(c). Here d and A are the previous stage's decisions (±1) and the fixed amplitudes, and all users use the same previous decisions.
- R7: With stage count n (0..3), exactly n stages run after the matched filter. `out_valid` rises on the (n+1)-th rising edge after the accepting edge. With n = 0 the outputs are the matched-filter values.
- R8: When the codes are mutually orthogonal (Walsh rows 1..15, bit = parity of row AND chip index), the correlations after any number of stages equal the matched-filter correlations.
- R9: After reset, `in_ready` is 1, `out_valid` is 0, and `dec_o` and `corr_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Symbol present on the input |
| in_ready | output | 1 | Block can take a symbol |
| rx_chips | input | SF*CHIP_W (128) | Received chips, chip c at bits [CHIP_W*c +: CHIP_W] |
| spread_codes | input | NU*SF (240) | Code bits, user u chip c at bit SF*u+c, 1 means −1 |
| stage_cnt | input | STG_W (2) | Number of cancellation stages for this symbol |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Sink takes the result |
| dec_o | output | NU (15) | Final decisions, 1 means +1 |
| corr_o | output | NU*CORR_W (270) | Final signed correlations, user u at [CORR_W*u +: CORR_W] |

## Verification
Each symbol is checked against an arithmetic model, and every symbol is repeated at stage counts 0 through 3. Symbols spread with Walsh rows confirm that cancellation leaves the matched-filter result unchanged. Symbols spread with pseudo-random, non-orthogonal codes at near-far power ratios show the stage arithmetic actually removing interference and changing correlations from stage to stage. All-zero chips exercise the zero-maps-to-+1 rule. Full-scale negative chips with identical codes drive every width to its largest value. A randomized sweep with output back-pressure and input toggling while a result is held separates the capture, hold and release rules from the arithmetic.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MF    = 2'd1,
    ST_STAGE = 2'd2,
    ST_HOLD  = 2'd3
  } pic_state_e;
endpackage

// File: rtl/pic_correlator.sv
module pic_correlator #(
  parameter int SF    = 16,
  parameter int IN_W  = 14,
  parameter int OUT_W = 18
) (
  input  logic signed [IN_W-1:0]  chip_i [SF],
  input  logic        [SF-1:0]    code_i,
  output logic signed [OUT_W-1:0] corr_o
);
  logic signed [OUT_W-1:0] acc;
  logic signed [OUT_W-1:0] ext;

  always_comb begin
    acc = '0;
    ext = '0;
    for (int c = 0; c < SF; c++) begin
      ext = {{(OUT_W-IN_W){chip_i[c][IN_W-1]}}, chip_i[c]};
      if (code_i[c]) acc = acc - ext;
      else           acc = acc + ext;
    end
  end

  assign corr_o = acc;
endmodule

// File: rtl/pic_rebuild.sv
module pic_rebuild #(
  parameter int NU    = 15,
  parameter int SF    = 16,
  parameter int AMP_W = 8,
  parameter int SUM_W = 13
) (
  input  logic        [AMP_W-1:0] amp_i  [NU],
  input  logic        [NU-1:0]    dec_i,
  input  logic        [SF-1:0]    code_i [NU],
  output logic signed [SUM_W-1:0] sum_o  [SF]
);
  for (genvar c = 0; c < SF; c++) begin : g_chip
    logic signed [SUM_W-1:0] acc;
    logic signed [SUM_W-1:0] term;
    always_comb begin
      acc  = '0;
      term = '0;
      for (int u = 0; u < NU; u++) begin
        term = {{(SUM_W-AMP_W){1'b0}}, amp_i[u]};
        // product of decision (+1 when 1) and chip (+1 when 0) is +1 when they differ
        if (dec_i[u] != code_i[u][c]) acc = acc + term;
        else                          acc = acc - term;
      end
    end
    assign sum_o[c] = acc;
  end
endmodule

// File: rtl/pic_seq.sv
module pic_seq
  import pic_pkg::*;
#(
  parameter int STG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid_i,
  input  logic             out_ready_i,
  input  logic [STG_W-1:0] stage_cnt_i,
  output logic             in_ready_o,
  output logic             out_valid_o,
  output logic             accept_o,
  output logic             cap_mf_o,
  output logic             cap_stage_o
);
  pic_state_e       state_q;
  logic [STG_W-1:0] nst_q;
  logic [STG_W-1:0] cnt_q;

  assign in_ready_o  = (state_q == ST_IDLE);
  assign out_valid_o = (state_q == ST_HOLD);
  assign accept_o    = in_valid_i && in_ready_o;
  assign cap_mf_o    = (state_q == ST_MF);
  assign cap_stage_o = (state_q == ST_STAGE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      nst_q   <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (in_valid_i) begin
          nst_q   <= stage_cnt_i;
          state_q <= ST_MF;
        end
        ST_MF: begin
          cnt_q   <= STG_W'(1);
          state_q <= (nst_q == '0) ? ST_HOLD : ST_STAGE;
        end
        ST_STAGE: begin
          if (cnt_q == nst_q) state_q <= ST_HOLD;
          else                cnt_q   <= cnt_q + STG_W'(1);
        end
        ST_HOLD: if (out_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: a pending result blocks the input side
  assert_one_in_flight_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready_o && out_valid_o));
  // R2: result stays until taken
  assert_hold_until_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i |=> out_valid_o);
  // R2: release returns to empty
  assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && out_ready_i |=> in_ready_o);
  // R7: accept is always followed by the matched-filter pass
  assert_mf_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> cap_mf_o && !out_valid_o);
  // R7: stage counter stays within the requested count
  assert_stage_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stage_o |-> (cnt_q != '0) && (cnt_q <= nst_q));
endmodule

// File: rtl/pic_canceller.sv
module pic_canceller
  import pic_pkg::*;
#(
  parameter  int NU     = 15,
  parameter  int SF     = 16,
  parameter  int CHIP_W = 8,
  parameter  int STG_W  = 2,
  localparam int LOG2SF = $clog2(SF),
  localparam int AMP_W  = CHIP_W,
  localparam int SUM_W  = CHIP_W + $clog2(NU) + 1,
  localparam int YW     = SUM_W + 1,
  localparam int CORR_W = YW + LOG2SF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [SF*CHIP_W-1:0]   rx_chips,
  input  logic [NU*SF-1:0]       spread_codes,
  input  logic [STG_W-1:0]       stage_cnt,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [NU-1:0]          dec_o,
  output logic [NU*CORR_W-1:0]   corr_o
);
  logic accept, cap_mf, cap_stage;

  pic_seq #(.STG_W(STG_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid_i  (in_valid),
    .out_ready_i (out_ready),
    .stage_cnt_i (stage_cnt),
    .in_ready_o  (in_ready),
    .out_valid_o (out_valid),
    .accept_o    (accept),
    .cap_mf_o    (cap_mf),
    .cap_stage_o (cap_stage)
  );

  // captured symbol
  logic signed [CHIP_W-1:0] r_q    [SF];
  logic        [SF-1:0]     code_q [NU];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < SF; c++) r_q[c] <= '0;
      for (int u = 0; u < NU; u++) code_q[u] <= '0;
    end else if (accept) begin
      for (int c = 0; c < SF; c++) r_q[c] <= rx_chips[c*CHIP_W +: CHIP_W];
      for (int u = 0; u < NU; u++) code_q[u] <= spread_codes[u*SF +: SF];
    end
  end

  // per-user state
  logic signed [CORR_W-1:0] z_q   [NU];
  logic        [NU-1:0]     dec_q;
  logic        [AMP_W-1:0]  amp_q [NU];

  // chip-level rebuilt sum of all users
  logic signed [SUM_W-1:0] s_w [SF];

  pic_rebuild #(.NU(NU), .SF(SF), .AMP_W(AMP_W), .SUM_W(SUM_W)) u_rebuild (
    .amp_i  (amp_q),
    .dec_i  (dec_q),
    .code_i (code_q),
    .sum_o  (s_w)
  );

  // per-user cleaned chips and shared correlator bank
  logic signed [YW-1:0]     y_w    [NU][SF];
  logic signed [CORR_W-1:0] corr_w [NU];
  logic        [CORR_W-1:0] abs_w  [NU];

  for (genvar u = 0; u < NU; u++) begin : g_user
    logic signed [YW-1:0] amp_ext;
    assign amp_ext = {{(YW-AMP_W){1'b0}}, amp_q[u]};

    for (genvar c = 0; c < SF; c++) begin : g_chip
      logic signed [YW-1:0] r_ext, s_ext, own;
      assign r_ext = {{(YW-CHIP_W){r_q[c][CHIP_W-1]}}, r_q[c]};
      assign s_ext = {{(YW-SUM_W){s_w[c][SUM_W-1]}}, s_w[c]};
      assign own   = (dec_q[u] != code_q[u][c]) ? amp_ext : -amp_ext;
      assign y_w[u][c] = cap_mf ? r_ext : (r_ext - s_ext + own);
    end

    pic_correlator #(.SF(SF), .IN_W(YW), .OUT_W(CORR_W)) u_corr (
      .chip_i (y_w[u]),
      .code_i (code_q[u]),
      .corr_o (corr_w[u])
    );

    assign abs_w[u] = corr_w[u][CORR_W-1] ? -corr_w[u] : corr_w[u];

    assign dec_o[u] = dec_q[u];
    assign corr_o[u*CORR_W +: CORR_W] = z_q[u];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q <= '0;
      for (int u = 0; u < NU; u++) begin
        z_q[u]   <= '0;
        amp_q[u] <= '0;
      end
    end else begin
      if (cap_mf || cap_stage) begin
        for (int u = 0; u < NU; u++) begin
          z_q[u]   <= corr_w[u];
          dec_q[u] <= ~corr_w[u][CORR_W-1];
        end
      end
      if (cap_mf) begin
        for (int u = 0; u < NU; u++) amp_q[u] <= abs_w[u][LOG2SF +: AMP_W];
      end
    end
  end

  // R2: held result does not move
  assert_out_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(corr_o) && $stable(dec_o));
  // R5: amplitudes frozen across cancellation stages
  assert_amp_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stage |=> $stable(amp_q[0]) && $stable(amp_q[NU-1]));
  // R1: captured chips only change on accept
  assert_capture_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(r_q[0]) && $stable(code_q[0]));
endmodule

// File: tb/test_pic_canceller.sv
module test_pic_canceller;
  localparam int NU = 15;
  localparam int SF = 16;
  localparam int CW = 8;
  localparam int STG_W = 2;
  localparam int CORR_W = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [SF*CW-1:0] rx_chips = '0;
  logic [NU*SF-1:0] spread_codes = '0;
  logic [STG_W-1:0] stage_cnt = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [NU-1:0] dec_o;
  logic [NU*CORR_W-1:0] corr_o;

  always #5 clk = ~clk;

  pic_canceller i_pic_canceller (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .rx_chips(rx_chips), .spread_codes(spread_codes), .stage_cnt(stage_cnt),
    .out_valid(out_valid), .out_ready(out_ready), .dec_o(dec_o), .corr_o(corr_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [31:0] seed = 32'h1234_5678;

  int r_v [SF];
  bit code_b [NU][SF];
  int exp_z [NU];
  int exp_d [NU];
  int mf_z  [NU];

  task automatic check(input string req, input string what, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic rnd(output int unsigned v);
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    v = seed;
  endtask

  function automatic int wv(int u, int c);
    return code_b[u][c] ? -1 : 1;
  endfunction

  // arithmetic reference of the requirements R3..R6
  task automatic model(input int n);
    int a [NU];
    int d [NU];
    int s [SF];
    int zn [NU];
    for (int u = 0; u < NU; u++) begin
      int acc = 0;
      for (int c = 0; c < SF; c++) acc += r_v[c] * wv(u, c);
      exp_z[u] = acc;
      d[u] = (acc >= 0) ? 1 : -1;
      a[u] = ((acc < 0) ? -acc : acc) / 16;
    end
    for (int k = 0; k < n; k++) begin
      for (int c = 0; c < SF; c++) begin
        s[c] = 0;
        for (int u = 0; u < NU; u++) s[c] += d[u] * a[u] * wv(u, c);
      end
      for (int u = 0; u < NU; u++) begin
        int acc = 0;
        for (int c = 0; c < SF; c++)
          acc += (r_v[c] - s[c] + d[u] * a[u] * wv(u, c)) * wv(u, c);
        zn[u] = acc;
      end
      for (int u = 0; u < NU; u++) begin
        exp_z[u] = zn[u];
        d[u] = (zn[u] >= 0) ? 1 : -1;
      end
    end
    for (int u = 0; u < NU; u++) exp_d[u] = d[u];
  endtask

  task automatic set_walsh();
    for (int u = 0; u < NU; u++)
      for (int c = 0; c < SF; c++)
        code_b[u][c] = ^(5'(u + 1) & 5'(c));
  endtask

  task automatic set_random_codes();
    int unsigned v;
    for (int u = 0; u < NU; u++) begin
      rnd(v);
      for (int c = 0; c < SF; c++) code_b[u][c] = v[c];
    end
  endtask

  // builds chips from user bits/amplitudes plus small noise, clipped to 8 bits
  task automatic make_chips(input int amp_max, input int noise);
    int unsigned v;
    int b [NU];
    int am [NU];
    for (int u = 0; u < NU; u++) begin
      rnd(v);
      b[u] = v[0] ? 1 : -1;
      am[u] = 1 + int'(v[15:8]) % amp_max;
    end
    for (int c = 0; c < SF; c++) begin
      int x = 0;
      for (int u = 0; u < NU; u++) x += b[u] * am[u] * wv(u, c);
      rnd(v);
      if (noise > 0) x += int'(v[7:0]) % (2 * noise + 1) - noise;
      if (x > 127) x = 127;
      if (x < -128) x = -128;
      r_v[c] = x;
    end
  endtask

  // runs one symbol; hold > 0 applies output back-pressure for that many cycles
  task automatic run_sym(input int n, input int hold, input string tag);
    int lat;
    logic [NU-1:0] dsnap;
    logic [NU*CORR_W-1:0] csnap;
    model(n);
    @(negedge clk);
    check("R1", {tag, " in_ready before accept"}, int'(in_ready), 1);
    for (int c = 0; c < SF; c++) rx_chips[c*CW +: CW] = r_v[c][CW-1:0];
    for (int u = 0; u < NU; u++)
      for (int c = 0; c < SF; c++) spread_codes[u*SF + c] = code_b[u][c];
    stage_cnt = STG_W'(n);
    in_valid = 1'b1;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    rx_chips = ~rx_chips;          // R1: post-accept changes must not matter
    spread_codes = ~spread_codes;
    stage_cnt = ~stage_cnt;
    lat = 0;
    while (lat < 20) begin
      @(negedge clk);
      lat++;
      if (out_valid) break;
      if (in_ready) begin
        check("R1", {tag, " in_ready while busy"}, 1, 0);
      end
    end
    check("R7", {tag, " latency (negedges after accept)"}, lat, n + 2);
    for (int u = 0; u < NU; u++) begin
      logic signed [CORR_W-1:0] cz;
      cz = corr_o[u*CORR_W +: CORR_W];
      check("R6", {tag, $sformatf(" corr user %0d n=%0d", u, n)}, int'(cz), exp_z[u]);
      check("R4", {tag, $sformatf(" dec user %0d", u)}, int'(dec_o[u]), (exp_d[u] > 0) ? 1 : 0);
    end
    if (hold > 0) begin
      dsnap = dec_o;
      csnap = corr_o;
      in_valid = 1'b1;             // must be ignored while a result is held
      for (int k = 0; k < hold; k++) begin
        @(negedge clk);
        check("R2", {tag, " out_valid held"}, int'(out_valid), 1);
        check("R2", {tag, " in_ready low while held"}, int'(in_ready), 0);
        check("R2", {tag, " dec stable"}, int'(dec_o == dsnap), 1);
        check("R2", {tag, " corr stable"}, int'(corr_o == csnap), 1);
      end
      in_valid = 1'b0;
    end
    out_ready = 1'b1;
    @(posedge clk);
    #1;
    out_ready = 1'b0;
    @(negedge clk);
    check("R2", {tag, " released"}, int'(out_valid), 0);
    check("R2", {tag, " in_ready after release"}, int'(in_ready), 1);
  endtask

  initial begin
    #(1_500_000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned v;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", "in_ready in reset", int'(in_ready), 1);
    check("R9", "out_valid in reset", int'(out_valid), 0);
    check("R9", "dec_o in reset", int'(dec_o == '0), 1);
    check("R9", "corr_o in reset", int'(corr_o == '0), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R8: orthogonal codes, every stage count gives the matched-filter result
    set_walsh();
    for (int p = 0; p < 3; p++) begin
      make_chips(8, 4);
      model(0);
      for (int u = 0; u < NU; u++) mf_z[u] = exp_z[u];
      for (int n = 0; n < 4; n++) begin
        run_sym(n, 0, "walsh");
        for (int u = 0; u < NU; u++)
          check("R8", $sformatf("walsh corr equals MF user %0d n=%0d", u, n), exp_z[u], mf_z[u]);
      end
    end

    // R5 R6: non-orthogonal codes, near-far powers, stages change the result
    for (int p = 0; p < 4; p++) begin
      set_random_codes();
      make_chips(12, 2);
      for (int n = 0; n < 4; n++) run_sym(n, (n == 2) ? 3 : 0, "nonorth");
    end

    // R4: zero chips map to +1 decisions and zero correlations
    for (int c = 0; c < SF; c++) r_v[c] = 0;
    set_random_codes();
    for (int n = 0; n < 4; n++) run_sym(n, 0, "zero");

    // R3 R6: full-scale negative chips, identical codes, widest values
    for (int c = 0; c < SF; c++) r_v[c] = -128;
    for (int u = 0; u < NU; u++) for (int c = 0; c < SF; c++) code_b[u][c] = 1'b1;
    for (int n = 0; n < 4; n++) run_sym(n, 0, "fullscale");

    // R1 R2 R7: randomized sweep with back-pressure
    for (int p = 0; p < 32; p++) begin
      rnd(v);
      if (v[0]) set_walsh(); else set_random_codes();
      make_chips(1 + int'(v[7:4]), int'(v[9:8]));
      run_sym(int'(v[3:2]), int'(v[12:11]), "sweep");
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule